// File: doc/BRIEF.md
# Software/Hardware Prefetch Request Arbiter

This block stands in front of a prefetch pipeline that can take one request per clock. It receives instruction-prefetch hints from several load-unit ports and ordinary prefetch requests from the fetch target queue, and it forwards at most one of them per cycle. Each forwarded request says whether it came from software. A hardware request also carries its queue index. Software requests only check for a miss and refill the cache, and they never enter the main fetch path.

Software hints are accepted at once into a single holding slot. If several ports fire in the same cycle, the lowest-numbered port is kept and the others are dropped. If a new hint arrives while the slot is still waiting on a stalled pipeline, the new hint replaces the old one. A held hint always goes ahead of a hardware request. A full flush empties the slot and blocks both directions for that cycle. A predictor redirect works differently. It leaves the held software hint alone and suppresses only a hardware request whose queue index matches the redirect index.

Top module: `pf_arbiter`

## Requirements
- R1: After reset the slot is empty, and with no inputs active out_valid is 0.
- R2: When several software ports are valid in the same cycle, only the one with the lowest index is kept. The hints on the other ports are discarded, although their ready is high.
- R3: A software hint accepted while the slot is occupied and not draining replaces the held hint. The next cycle presents the newest address.
- R4: While a software hint is held, it is the request presented (out_is_sw=1), and hw_ready stays 0 even if hw_valid is 1.
- R5: hw_ready is 1 only when none of these hold: flush is high, a hint is held, a software hint is arriving, or a matching redirect is active. out_ready must also be high. When a hardware request is presented, out_is_sw is 0, and the address and index pass through unchanged.
- R6: While flush is 1, out_valid, hw_ready and every bit of sw_ready are 0. The slot is empty in the following cycle.
- R7: When redir_valid is 1 and hw_idx equals redir_idx, the hardware request is not presented and hw_ready is 0. A held software hint is still presented. A hardware request with a different index passes.
- R8: A held hint leaves the slot on the cycle its out_valid/out_ready handshake completes. If no new hint arrives in that cycle, the next cycle presents no software request.
- R9: A software hint accepted in cycle n is presented from cycle n+1 with out_is_sw=1 and out_idx=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Full flush: empties the slot and blocks all handshakes this cycle |
| redir_valid | input | 1 | Predictor redirect is active |
| redir_idx | input | IDX_W | Queue index targeted by the redirect |
| sw_valid | input | NUM_SW | Software hint valid, one bit per load-unit port |
| sw_addr | input | NUM_SW*ADDR_W | Hint addresses; port i occupies bits [i*ADDR_W +: ADDR_W] |
| sw_ready | output | NUM_SW | Hint accepted (or dropped), one bit per port |
| hw_valid | input | 1 | Hardware prefetch request valid |
| hw_addr | input | ADDR_W | Hardware prefetch address |
| hw_idx | input | IDX_W | Queue index of the hardware request |
| hw_ready | output | 1 | Hardware request taken by the pipeline |
| out_valid | output | 1 | Request presented to the pipeline |
| out_ready | input | 1 | Pipeline can take the request |
| out_addr | output | ADDR_W | Presented address |
| out_idx | output | IDX_W | Queue index (0 for software) |
| out_is_sw | output | 1 | Presented request is a software hint |

## Verification
Directed sequences first feed the pipeline hardware-only traffic, with the pipeline both ready and stalled, so that pass-through can be told apart from back-pressure. Next they drive simultaneous hints on the upper ports only and then on all ports. This separates lowest-index selection from last-writer or highest-index selection. A second hint sent into a stalled slot shows whether the slot is overwritten or keeps its first entry. Flush and redirect cycles are applied with and without a held hint, using both matching and non-matching queue indices, and a long random mix follows. A behavioural reference model checks every cycle of all these sequences.

// File: rtl/pf_arb_pkg.sv
package pf_arb_pkg;
    localparam int PF_NUM_SW = 3;
    localparam int PF_ADDR_W = 40;
    localparam int PF_IDX_W  = 6;
endpackage

// File: rtl/pf_sw_select.sv
module pf_sw_select #(
    parameter int NUM_SW = pf_arb_pkg::PF_NUM_SW,
    parameter int ADDR_W = pf_arb_pkg::PF_ADDR_W
) (
    input  logic [NUM_SW-1:0]        req_v,
    input  logic [NUM_SW*ADDR_W-1:0] req_addr,
    output logic                     any_v,
    output logic [ADDR_W-1:0]        win_addr
);
    logic [NUM_SW:0]   seen;
    logic [NUM_SW-1:0] pick;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SW; g++) begin : g_chain
        assign pick[g]     = req_v[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_v[g];
    end

    assign any_v = seen[NUM_SW];

    always_comb begin
        win_addr = '0;
        for (int i = 0; i < NUM_SW; i++) begin
            win_addr = win_addr | (req_addr[i*ADDR_W +: ADDR_W] & {ADDR_W{pick[i]}});
        end
    end
endmodule

// File: rtl/pf_sw_slot.sv
module pf_sw_slot #(
    parameter int ADDR_W = pf_arb_pkg::PF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              drain,
    output logic              held_v,
    output logic [ADDR_W-1:0] held_addr
);
    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.v = 1'b0;
        end else if (load) begin
            st_d.v    = 1'b1;
            st_d.addr = load_addr;
        end else if (drain) begin
            st_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_v    = st_q.v;
    assign held_addr = st_q.addr;
endmodule

// File: rtl/pf_arbiter.sv
module pf_arbiter #(
    parameter int NUM_SW = pf_arb_pkg::PF_NUM_SW,
    parameter int ADDR_W = pf_arb_pkg::PF_ADDR_W,
    parameter int IDX_W  = pf_arb_pkg::PF_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     redir_valid,
    input  logic [IDX_W-1:0]         redir_idx,
    input  logic [NUM_SW-1:0]        sw_valid,
    input  logic [NUM_SW*ADDR_W-1:0] sw_addr,
    output logic [NUM_SW-1:0]        sw_ready,
    input  logic                     hw_valid,
    input  logic [ADDR_W-1:0]        hw_addr,
    input  logic [IDX_W-1:0]         hw_idx,
    output logic                     hw_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [ADDR_W-1:0]        out_addr,
    output logic [IDX_W-1:0]         out_idx,
    output logic                     out_is_sw
);
    logic              sw_any;
    logic [ADDR_W-1:0] sw_win;
    logic              sw_take;
    logic              held_v;
    logic [ADDR_W-1:0] held_addr;
    logic              hw_cancel;
    logic              hw_eligible;

    pf_sw_select #(.NUM_SW(NUM_SW), .ADDR_W(ADDR_W)) u_sel (
        .req_v    (sw_valid),
        .req_addr (sw_addr),
        .any_v    (sw_any),
        .win_addr (sw_win)
    );

    assign sw_take = sw_any & ~flush;

    pf_sw_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .load      (sw_take),
        .load_addr (sw_win),
        .drain     (out_ready),
        .held_v    (held_v),
        .held_addr (held_addr)
    );

    // hardware request is suppressed by a redirect naming its queue index
    assign hw_cancel   = redir_valid & (hw_idx == redir_idx);
    assign hw_eligible = hw_valid & ~hw_cancel & ~sw_take & ~held_v;

    always_comb begin
        out_valid = ~flush & (held_v | hw_eligible);
        out_is_sw = held_v;
        out_addr  = held_v ? held_addr : hw_addr;
        out_idx   = held_v ? '0 : hw_idx;
        hw_ready  = ~flush & ~held_v & ~sw_take & ~hw_cancel & out_ready;
        sw_ready  = {NUM_SW{~flush}};
    end
endmodule

// File: rtl/pf_arbiter_chk.sv
module pf_arbiter_chk #(
    parameter int NUM_SW = pf_arb_pkg::PF_NUM_SW,
    parameter int ADDR_W = pf_arb_pkg::PF_ADDR_W,
    parameter int IDX_W  = pf_arb_pkg::PF_IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              redir_valid,
    input logic [IDX_W-1:0]  redir_idx,
    input logic [NUM_SW-1:0] sw_valid,
    input logic              hw_valid,
    input logic [IDX_W-1:0]  hw_idx,
    input logic              hw_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_is_sw
);
    a_r6_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!out_valid && !hw_ready));

    a_r4_sw_blocks_hw: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_sw) |-> !hw_ready);

    a_r5_hw_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ready |-> (hw_valid ? (out_valid && !out_is_sw && out_ready) : (!out_is_sw && out_ready)));

    a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (|sw_valid)) |=> out_is_sw);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_is_sw && !(|sw_valid)) |=> !out_is_sw);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_sw && !out_ready && !flush && !(|sw_valid)) |=> (out_is_sw && $stable(out_addr)));

    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && (hw_idx == redir_idx) && !out_is_sw) |-> !out_valid);
endmodule

bind pf_arbiter pf_arbiter_chk #(.NUM_SW(NUM_SW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .redir_valid (redir_valid),
    .redir_idx   (redir_idx),
    .sw_valid    (sw_valid),
    .hw_valid    (hw_valid),
    .hw_idx      (hw_idx),
    .hw_ready    (hw_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_is_sw   (out_is_sw)
);

// File: tb/pf_arbiter_bench.sv
`timescale 1ns/1ps
module pf_arbiter_bench;
    localparam int NSW = 3;
    localparam int AW  = 40;
    localparam int IW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              redir_valid = 1'b0;
    logic [IW-1:0]     redir_idx = '0;
    logic [NSW-1:0]    sw_valid = '0;
    logic [NSW*AW-1:0] sw_addr = '0;
    logic [NSW-1:0]    sw_ready;
    logic              hw_valid = 1'b0;
    logic [AW-1:0]     hw_addr = '0;
    logic [IW-1:0]     hw_idx = '0;
    logic              hw_ready;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [AW-1:0]     out_addr;
    logic [IW-1:0]     out_idx;
    logic              out_is_sw;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state: one held hint or none
    bit          m_held = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #4 clk = ~clk;

    pf_arbiter u_pf_arbiter (
        .clk(clk), .rst_n(rst_n), .flush(flush), .redir_valid(redir_valid),
        .redir_idx(redir_idx), .sw_valid(sw_valid), .sw_addr(sw_addr),
        .sw_ready(sw_ready), .hw_valid(hw_valid), .hw_addr(hw_addr),
        .hw_idx(hw_idx), .hw_ready(hw_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_idx(out_idx),
        .out_is_sw(out_is_sw)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // apply inputs for one cycle (already set at negedge), compare, then advance
    task automatic cycle(input string tag);
        bit take;
        logic [AW-1:0] win;
        bit cancel;
        bit e_valid;
        bit e_hwr;
        take = 1'b0;
        win = '0;
        #1;
        if (!flush) begin
            for (int i = NSW - 1; i >= 0; i--) begin
                if (sw_valid[i]) begin
                    take = 1'b1;
                    win  = sw_addr[i*AW +: AW];
                end
            end
        end
        cancel  = redir_valid && (hw_idx == redir_idx);
        e_valid = !flush && (m_held || (hw_valid && !take && !cancel));
        e_hwr   = !flush && !m_held && !take && !cancel && out_ready;
        chk(tag, "out_valid", 64'(out_valid), 64'(e_valid));
        chk(tag, "hw_ready", 64'(hw_ready), 64'(e_hwr));
        chk(tag, "sw_ready", 64'(sw_ready), flush ? 64'd0 : 64'((1 << NSW) - 1));
        if (e_valid) begin
            chk(tag, "out_is_sw", 64'(out_is_sw), 64'(m_held));
            chk(tag, "out_addr", 64'(out_addr), m_held ? 64'(m_addr) : 64'(hw_addr));
            chk(tag, "out_idx", 64'(out_idx), m_held ? 64'd0 : 64'(hw_idx));
        end
        @(posedge clk);
        if (flush) m_held = 1'b0;
        else if (take) begin
            m_held = 1'b1;
            m_addr = win;
        end else if (m_held && out_ready) m_held = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        flush = 0; redir_valid = 0; sw_valid = '0; hw_valid = 0; out_ready = 0;
    endtask

    task automatic set_sw(input int port, input logic [AW-1:0] a);
        sw_valid[port] = 1'b1;
        sw_addr[port*AW +: AW] = a;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle();
        cycle("R1");                                   // reset state
        // hardware only
        hw_valid = 1; hw_addr = 40'h12_3456_7000; hw_idx = 6'd5; out_ready = 1;
        cycle("R5");
        out_ready = 0;
        cycle("R5");                                   // stalled pipeline
        // upper ports only: port 1 must win over port 2
        set_sw(1, 40'h00_AAAA_0040); set_sw(2, 40'h00_BBBB_0080);
        cycle("R2");
        sw_valid = '0;
        cycle("R9");                                   // port 1 hint presented, hw held off (R4)
        cycle("R4");
        // overwrite while stalled, all ports valid -> port 0
        set_sw(0, 40'h00_CCCC_00C0); set_sw(1, 40'h00_DDDD_0100); set_sw(2, 40'h00_EEEE_0140);
        cycle("R3");
        sw_valid = '0;
        cycle("R3");
        out_ready = 1;
        cycle("R8");                                   // hint drains
        cycle("R8");                                   // hardware flows again
        // flush with a held hint
        set_sw(2, 40'h00_1111_0200); out_ready = 0;
        cycle("R9");
        sw_valid = '0; flush = 1;
        cycle("R6");
        flush = 0;
        cycle("R6");                                   // slot empty afterwards
        // redirect
        redir_valid = 1; redir_idx = 6'd5; out_ready = 1;
        cycle("R7");                                   // matching index suppressed
        hw_idx = 6'd9;
        cycle("R7");                                   // non-matching passes
        hw_idx = 6'd5; out_ready = 0; set_sw(0, 40'h00_2222_0240);
        cycle("R7");
        sw_valid = '0;
        cycle("R7");                                   // held hint survives redirect
        idle();
        // random mix
        for (int n = 0; n < 4000; n++) begin
            flush       = ($urandom % 16) == 0;
            redir_valid = ($urandom % 6) == 0;
            redir_idx   = IW'($urandom % 4);
            sw_valid    = NSW'(($urandom % 3) == 0 ? $urandom : 0);
            for (int p = 0; p < NSW; p++) sw_addr[p*AW +: AW] = {8'h0, $urandom};
            hw_valid    = $urandom % 2;
            hw_addr     = {8'h0, $urandom};
            hw_idx      = IW'($urandom % 4);
            out_ready   = ($urandom % 3) != 0;
            cycle("R5");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule